// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The sequencer gathers every condition that may restart the chip and turns them into two synchronous reset outputs. The full reset clears all logic. The partial reset clears everything except the I/O base address register and the self-control register. Those two registers take only the full reset as their reset; all other registers take the partial reset.

The causes are as follows. An external reset pin must stay high for a minimum number of clock cycles before it counts. Supply-good and oscillator-stable flags come from analog detectors outside the block. There is a checksum-error flag from the EEPROM loader. A software reset bit is set by a host write strobe and clears itself. Any change of the hardware standby or hardware suspend mode inputs, in either direction, is a cause. The software suspend mode input is the last one. All asynchronous inputs pass through synchronizers first. A power-on reset input (`por_n`, asynchronous, active low) initialises the whole block, including the cause status.

A state machine with four states sequences the resets:
- `ST_PWR_WAIT`: full reset is held until supply and oscillator are both good.
- `ST_STRETCH`: full reset is held for a fixed number of cycles after the last active cause.
- `ST_RUN`: normal operation.
- `ST_SW_SUSP`: only the partial reset is held.

The named transitions are:
- Power-on reset enters `ST_PWR_WAIT`.
- `ST_PWR_WAIT` goes to `ST_STRETCH` when power is ready.
- Any state goes to `ST_PWR_WAIT` when the supply is lost.
- `ST_RUN` or `ST_SW_SUSP` goes to `ST_STRETCH` on a trigger.
- `ST_STRETCH` goes to `ST_RUN` when the stretch counter expires.
- `ST_RUN` goes to `ST_SW_SUSP` on suspend entry.
- `ST_SW_SUSP` goes to `ST_STRETCH` on suspend exit.

Top module: `rst_seq_top`

## Requirements
- R1: After `por_n` is released, `full_rst` and `part_rst` stay high and `last_cause` reads 0 (power-on) for as long as `supply_good` or `osc_stable` is low.
- R2: If `supply_good` falls while the block is out of reset, `full_rst` goes high and `last_cause` becomes 1. Release comes only after both `supply_good` and `osc_stable` are high again, followed by the stretch.
- R3: `ext_rst_pin` high for at least PIN_MIN_CYC consecutive cycles (100 by default) causes a full reset and sets `last_cause` to 2. A shorter pulse, including one of PIN_MIN_CYC-1 cycles, has no effect.
- R4: `csum_err` high causes a full reset and sets `last_cause` to 3.
- R5: A one-cycle `soft_rst_wr` sets `soft_rst_bit` on the next edge. That bit causes a full reset and sets `last_cause` to 4, and the bit reads 0 again once the reset has begun.
- R6: Each change of `hw_standby` or `hw_suspend`, rising or falling, causes a full reset and sets `last_cause` to 5.
- R7: `sw_suspend` going high while the block is running drives `part_rst` high and keeps `full_rst` low for as long as it stays high. `last_cause` becomes 6.
- R8: `sw_suspend` going low while suspended causes a full reset and sets `last_cause` to 7.
- R9: `full_rst` stays high for at least STRETCH_CYC cycles (16 by default) after its cause is last seen, and is then released on a clock edge. `part_rst` is high whenever `full_rst` is high.
- R10: `last_cause` keeps its value through every reset except `por_n`. When several triggers appear in the same cycle, the priority is supply, then pin, then checksum, then software, then mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_pin | input | 1 | External reset pin, asynchronous |
| supply_good | input | 1 | Supply above threshold, asynchronous |
| osc_stable | input | 1 | Oscillator settled, asynchronous |
| csum_err | input | 1 | EEPROM checksum error flag, asynchronous |
| hw_standby | input | 1 | Hardware standby mode level, asynchronous |
| hw_suspend | input | 1 | Hardware suspend mode level, asynchronous |
| sw_suspend | input | 1 | Software suspend mode level, asynchronous |
| soft_rst_wr | input | 1 | Synchronous strobe setting the software reset bit |
| full_rst | output | 1 | Chip-wide reset, active high |
| part_rst | output | 1 | Reset for all but the two kept registers |
| soft_rst_bit | output | 1 | Readback of the self-clearing software reset bit |
| last_cause | output | 3 | Code of the most recent reset cause |

## Verification
The bench aims at the pin filter boundary. A 99-cycle pulse must pass without effect and a 100-cycle pulse must reset the chip. A filter that is off by one either misses the legal pulse or resets on a glitch.

Suspend is checked for the split between the two outputs. A design that mixed them up would clear the kept registers on suspend entry, or leave the chip unreset on exit.

Mode changes are driven in both directions, because a detector that catches only rising edges stays silent when standby is left. A checksum error is made to coincide with a mode change so that the cause priority is exercised.

The software bit is read back before and after its reset. A bit that does not clear itself would loop the chip in reset forever.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_PWR_WAIT = 2'd0,
        ST_STRETCH  = 2'd1,
        ST_RUN      = 2'd2,
        ST_SW_SUSP  = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        CAUSE_POR      = 3'd0,
        CAUSE_SUPPLY   = 3'd1,
        CAUSE_PIN      = 3'd2,
        CAUSE_CSUM     = 3'd3,
        CAUSE_SOFT     = 3'd4,
        CAUSE_HW_MODE  = 3'd5,
        CAUSE_SUSP_IN  = 3'd6,
        CAUSE_SUSP_OUT = 3'd7
    } rst_cause_e;

endpackage

// File: rtl/rst_sync_bank.sv
module rst_sync_bank #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain <= '0;
                else        chain <= d_async[b];
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async[b]};
            end
        end
        assign d_sync[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int PIN_MIN_CYC = 100
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_s,
    output logic pin_qual
);

    localparam int PW = $clog2(PIN_MIN_CYC + 1);
    localparam logic [PW-1:0] LIMIT = PW'(PIN_MIN_CYC);

    logic [PW-1:0] high_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              high_cnt <= '0;
        else if (!pin_s)         high_cnt <= '0;
        else if (high_cnt != LIMIT) high_cnt <= high_cnt + 1'b1;
    end

    assign pin_qual = (high_cnt == LIMIT);

endmodule

// File: rtl/rst_mode_watch.sv
module rst_mode_watch #(
    parameter int N_MODES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [N_MODES-1:0] mode_s,
    output logic               mode_edge
);

    logic [N_MODES-1:0] mode_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= '0;
        else        mode_q <= mode_s;
    end

    assign mode_edge = |(mode_q ^ mode_s);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_ok,
    input  logic       osc_ok,
    input  logic       pin_trig,
    input  logic       csum_trig,
    input  logic       soft_trig,
    input  logic       mode_trig,
    input  logic       sw_susp,
    output logic       full_rst,
    output logic       part_rst,
    output rst_cause_e last_cause,
    output seq_state_e state_o
);

    localparam int CNT_W = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    rst_cause_e       cause_q, cause_d;
    rst_cause_e       trig_code;
    logic             trig_any;

    // Priority among same-cycle triggers
    always_comb begin
        trig_any  = pin_trig | csum_trig | soft_trig | mode_trig;
        trig_code = CAUSE_HW_MODE;
        if (pin_trig)       trig_code = CAUSE_PIN;
        else if (csum_trig) trig_code = CAUSE_CSUM;
        else if (soft_trig) trig_code = CAUSE_SOFT;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (supply_ok && osc_ok) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                end
            end
            ST_STRETCH: begin
                if (!supply_ok) begin
                    state_d = ST_PWR_WAIT;
                    cause_d = CAUSE_SUPPLY;
                end else if (trig_any) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (!supply_ok) begin
                    state_d = ST_PWR_WAIT;
                    cause_d = CAUSE_SUPPLY;
                end else if (trig_any) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                    cause_d = trig_code;
                end else if (sw_susp) begin
                    state_d = ST_SW_SUSP;
                    cause_d = CAUSE_SUSP_IN;
                end
            end
            ST_SW_SUSP: begin
                if (!supply_ok) begin
                    state_d = ST_PWR_WAIT;
                    cause_d = CAUSE_SUPPLY;
                end else if (trig_any) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                    cause_d = trig_code;
                end else if (!sw_susp) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                    cause_d = CAUSE_SUSP_OUT;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_PWR_WAIT;
            cnt_q   <= '0;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cause_q <= cause_d;
        end
    end

    // Outputs
    always_comb begin
        full_rst = 1'b1;
        part_rst = 1'b1;
        unique case (state_q)
            ST_PWR_WAIT, ST_STRETCH: begin
                full_rst = 1'b1;
                part_rst = 1'b1;
            end
            ST_RUN: begin
                full_rst = 1'b0;
                part_rst = 1'b0;
            end
            ST_SW_SUSP: begin
                full_rst = 1'b0;
                part_rst = 1'b1;
            end
        endcase
    end

    assign last_cause = cause_q;
    assign state_o    = state_q;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int PIN_MIN_CYC = 100,
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_pin,
    input  logic       supply_good,
    input  logic       osc_stable,
    input  logic       csum_err,
    input  logic       hw_standby,
    input  logic       hw_suspend,
    input  logic       sw_suspend,
    input  logic       soft_rst_wr,
    output logic       full_rst,
    output logic       part_rst,
    output logic       soft_rst_bit,
    output logic [2:0] last_cause
);

    localparam int IX_PIN   = 0;
    localparam int IX_SUP   = 1;
    localparam int IX_OSC   = 2;
    localparam int IX_CSUM  = 3;
    localparam int IX_STBY  = 4;
    localparam int IX_HSUSP = 5;
    localparam int IX_SSUSP = 6;
    localparam int N_ASYNC  = 7;

    logic [N_ASYNC-1:0] raw_in, syn_in;
    logic               pin_qual, mode_edge;
    logic               supply_s, csum_s, sw_susp_s;
    seq_state_e         fsm_state;
    rst_cause_e         cause;

    assign raw_in = {sw_suspend, hw_suspend, hw_standby, csum_err,
                     osc_stable, supply_good, ext_rst_pin};

    rst_sync_bank #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async (raw_in),
        .d_sync  (syn_in)
    );

    assign supply_s  = syn_in[IX_SUP];
    assign csum_s    = syn_in[IX_CSUM];
    assign sw_susp_s = syn_in[IX_SSUSP];

    rst_pin_filter #(.PIN_MIN_CYC(PIN_MIN_CYC)) i_pin (
        .clk      (clk),
        .por_n    (por_n),
        .pin_s    (syn_in[IX_PIN]),
        .pin_qual (pin_qual)
    );

    rst_mode_watch #(.N_MODES(2)) i_mode (
        .clk       (clk),
        .por_n     (por_n),
        .mode_s    ({syn_in[IX_HSUSP], syn_in[IX_STBY]}),
        .mode_edge (mode_edge)
    );

    // Self-clearing software reset bit, kept register class
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          soft_rst_bit <= 1'b0;
        else if (full_rst)   soft_rst_bit <= 1'b0;
        else if (soft_rst_wr) soft_rst_bit <= 1'b1;
    end

    rst_seq_fsm #(.STRETCH_CYC(STRETCH_CYC)) i_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .supply_ok  (supply_s),
        .osc_ok     (syn_in[IX_OSC]),
        .pin_trig   (pin_qual),
        .csum_trig  (csum_s),
        .soft_trig  (soft_rst_bit),
        .mode_trig  (mode_edge),
        .sw_susp    (sw_susp_s),
        .full_rst   (full_rst),
        .part_rst   (part_rst),
        .last_cause (cause),
        .state_o    (fsm_state)
    );

    assign last_cause = cause;

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker
    import rst_seq_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input seq_state_e state,
    input logic       supply_s,
    input logic       csum_s,
    input logic       sw_susp_s,
    input logic       full_rst,
    input logic       part_rst,
    input logic       soft_bit
);

    logic [15:0] high_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              high_len <= '0;
        else if (!full_rst)      high_len <= '0;
        else if (high_len != 16'hFFFF) high_len <= high_len + 1'b1;
    end

    AST_FULL_IMPLIES_PART: assert property (@(posedge clk) disable iff (!por_n) full_rst |-> part_rst); // R9
    AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!por_n) $fell(full_rst) |-> (high_len >= 16'(STRETCH_CYC))); // R9
    AST_SOFT_BIT_CLEARS: assert property (@(posedge clk) disable iff (!por_n) full_rst |=> !soft_bit); // R5
    AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!por_n) ((state == ST_RUN || state == ST_SW_SUSP) && !supply_s) |=> full_rst); // R2
    AST_CSUM_RESET: assert property (@(posedge clk) disable iff (!por_n) (state == ST_RUN && csum_s) |=> full_rst); // R4
    AST_SUSP_EXIT: assert property (@(posedge clk) disable iff (!por_n) (state == ST_SW_SUSP && !sw_susp_s) |=> full_rst); // R8

endmodule

bind rst_seq_top rst_seq_checker #(.STRETCH_CYC(STRETCH_CYC)) i_chk (
    .clk       (clk),
    .por_n     (por_n),
    .state     (fsm_state),
    .supply_s  (supply_s),
    .csum_s    (csum_s),
    .sw_susp_s (sw_susp_s),
    .full_rst  (full_rst),
    .part_rst  (part_rst),
    .soft_bit  (soft_rst_bit)
);

// File: tb/test_rst_seq_top.sv
`timescale 1ns/1ps
module test_rst_seq_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_pin = 1'b0, supply_good = 1'b0, osc_stable = 1'b0;
    logic       csum_err = 1'b0, hw_standby = 1'b0, hw_suspend = 1'b0;
    logic       sw_suspend = 1'b0, soft_rst_wr = 1'b0;
    logic       full_rst, part_rst, soft_rst_bit;
    logic [2:0] last_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rst_seq_top i_rst_seq_top (
        .clk(clk), .por_n(por_n), .ext_rst_pin(ext_rst_pin),
        .supply_good(supply_good), .osc_stable(osc_stable),
        .csum_err(csum_err), .hw_standby(hw_standby),
        .hw_suspend(hw_suspend), .sw_suspend(sw_suspend),
        .soft_rst_wr(soft_rst_wr), .full_rst(full_rst),
        .part_rst(part_rst), .soft_rst_bit(soft_rst_bit),
        .last_cause(last_cause)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_release(input string req);
        cyc(8);
        chk(req, full_rst, 1);
        cyc(32);
        chk(req, full_rst, 0);
        chk(req, part_rst, 0);
    endtask

    task automatic t_power_on;
        cyc(3);
        por_n = 1'b1;
        cyc(5);
        chk("R1 full at por", full_rst, 1);
        chk("R1 part at por", part_rst, 1);
        chk("R1 cause por", last_cause, 0);
        supply_good = 1'b1;
        cyc(40);
        chk("R1 held without osc", full_rst, 1);
        osc_stable = 1'b1;
        expect_release("R1 release");
        chk("R1 cause kept", last_cause, 0);
    endtask

    task automatic t_supply_drop;
        supply_good = 1'b0;
        cyc(6);
        chk("R2 full on drop", full_rst, 1);
        chk("R2 cause", last_cause, 1);
        cyc(40);
        chk("R2 held while low", full_rst, 1);
        supply_good = 1'b1;
        expect_release("R2 release");
    endtask

    task automatic t_pin_filter;
        ext_rst_pin = 1'b1;
        cyc(99);
        ext_rst_pin = 1'b0;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            chk("R3 99-cycle pulse ignored", full_rst, 0);
        end
        chk("R3 cause untouched", last_cause, 1);
        ext_rst_pin = 1'b1;
        cyc(100);
        ext_rst_pin = 1'b0;
        cyc(6);
        chk("R3 100-cycle pulse resets", full_rst, 1);
        chk("R3 cause", last_cause, 2);
        expect_release("R3 release");
    endtask

    task automatic t_csum;
        csum_err = 1'b1;
        cyc(6);
        chk("R4 full on checksum", full_rst, 1);
        chk("R4 cause", last_cause, 3);
        cyc(30);
        chk("R4 held while flagged", full_rst, 1);
        csum_err = 1'b0;
        expect_release("R4 release");
    endtask

    task automatic t_soft;
        soft_rst_wr = 1'b1;
        cyc(1);
        soft_rst_wr = 1'b0;
        chk("R5 bit set", soft_rst_bit, 1);
        cyc(3);
        chk("R5 full on soft", full_rst, 1);
        chk("R5 bit self-clears", soft_rst_bit, 0);
        chk("R5 cause", last_cause, 4);
        expect_release("R5 release");
        chk("R10 cause kept after reset", last_cause, 4);
    endtask

    task automatic t_hw_modes;
        hw_standby = 1'b1;
        cyc(6);
        chk("R6 standby entry", full_rst, 1);
        chk("R6 cause", last_cause, 5);
        expect_release("R6 release entry");
        hw_standby = 1'b0;
        cyc(6);
        chk("R6 standby exit", full_rst, 1);
        expect_release("R6 release exit");
        hw_suspend = 1'b1;
        cyc(6);
        chk("R6 hw suspend entry", full_rst, 1);
        expect_release("R6 release hw suspend");
        hw_suspend = 1'b0;
        cyc(6);
        chk("R6 hw suspend exit", full_rst, 1);
        expect_release("R6 release hw suspend exit");
    endtask

    task automatic t_sw_suspend;
        sw_suspend = 1'b1;
        cyc(6);
        chk("R7 partial on entry", part_rst, 1);
        chk("R7 no full on entry", full_rst, 0);
        chk("R7 cause", last_cause, 6);
        cyc(40);
        chk("R7 partial held", part_rst, 1);
        chk("R7 full stays low", full_rst, 0);
        sw_suspend = 1'b0;
        cyc(6);
        chk("R8 full on exit", full_rst, 1);
        chk("R8 cause", last_cause, 7);
        expect_release("R8 release");
    endtask

    task automatic t_priority;
        csum_err   = 1'b1;
        hw_standby = 1'b1;
        cyc(6);
        chk("R10 full on combined", full_rst, 1);
        chk("R10 checksum beats mode", last_cause, 3);
        csum_err = 1'b0;
        expect_release("R10 release");
        hw_standby = 1'b0;
        expect_release("R10 release mode exit");
        por_n = 1'b0;
        cyc(2);
        chk("R10 cause cleared by por", last_cause, 0);
        por_n = 1'b1;
        expect_release("R9 release after por");
    endtask

    initial begin
        t_power_on();
        t_supply_drop();
        t_pin_filter();
        t_csum();
        t_soft();
        t_hw_modes();
        t_sw_suspend();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule